// File: doc/BRIEF.md
# UART Automatic Hardware Flow Controller

This block sits between a UART's receive FIFO, its transmit shifter and the modem-control pins, and carries out hardware flow control in both directions on its own. On the receive side it compares the FIFO fill count with a trigger level chosen by a 2-bit selector. It raises an interrupt once that level is reached. It drives RTS to logic 1 when the fill climbs one trigger step higher. It lets RTS fall back only when the fill has drained below the step one lower than the chosen one. Between those two points RTS holds its value, so it does not chatter.

On the transmit side the CTS pin is resynchronised and used to gate the start of each new character. The external shifter asks to begin a character with a request line, and the block grants the request only while CTS is not holding the link off. A character already on the wire is never cut short, because only starts are gated. Each direction has its own enable bit in an 8-bit feature configuration word. With the receive direction disabled, the RTS pin simply follows a software-driven modem-control bit.

Top module: `uart_hw_flowctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rx_trig_irq` is 0, `rts_pin` equals `sw_rts` and `tx_start` equals `tx_req`.
- R2: Bit 7 of `feat_cfg` enables automatic CTS gating and bit 6 enables automatic RTS. Bits 5 to 0 have no effect on any output.
- R3: With automatic RTS on, `rx_trig_irq` is 1 one rising edge after `rx_fill` is at or above the trigger level (`trig_sel` 0/1/2/3 selects 8/16/24/28). It is 0 one edge after the fill is below that level.
- R4: With automatic RTS on, `rts_pin` goes to 1 one rising edge after `rx_fill` reaches the next step above the trigger level (16/24/28/32 for `trig_sel` 0/1/2/3).
- R5: With automatic RTS on, `rts_pin` returns to 0 one rising edge after `rx_fill` drops below the next step below the trigger level (8/16/24 for `trig_sel` 1/2/3; for `trig_sel` 0, when the fill is 0). Between the two points it keeps its previous value.
- R6: With automatic RTS off, `rts_pin` equals `sw_rts` in the same cycle, and `rx_trig_irq` is 0 from the next edge on.
- R7: With automatic CTS on, `tx_start` is `tx_req` gated by `cts_pin` seen through a two-flop synchroniser. A change of `cts_pin` affects `tx_start` after the second rising edge. A character in progress completes, and no new one starts while CTS reads 1.
- R8: With automatic CTS off, `tx_start` equals `tx_req` whatever `cts_pin` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_cfg | input | 8 | Feature configuration word (bit 7 auto-CTS, bit 6 auto-RTS) |
| trig_sel | input | 2 | Receive trigger step select |
| rx_fill | input | CW (6) | Receive FIFO fill count, 0 to DEPTH |
| sw_rts | input | 1 | Software modem-control RTS bit |
| cts_pin | input | 1 | CTS pin, 1 = hold transmission |
| tx_req | input | 1 | Shifter idle with a character ready |
| rts_pin | output | 1 | RTS pin level |
| rx_trig_irq | output | 1 | Receive trigger-level interrupt |
| tx_start | output | 1 | Grant to begin the next character |

## Verification
`rts_pin` and `rx_trig_irq` in the automatic mode are due one rising edge after the `rx_fill` value that causes them. The bench applies every input just after a falling edge and compares all three outputs at the following falling edge, against a behavioural model advanced on the same rising edge. In software RTS mode and without CTS gating, the outputs follow their inputs within the cycle. A CTS change is due after two rising edges, and the bench measures that exact distance between releasing CTS and the next grant. Fill ramps up to 32 and back to 0 for every trigger selection, so each boundary and each hysteresis hold point is passed in both directions.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
   // Step ladder: 0 = below bottom, 1..4 = configured levels, 5+ = full depth
   function automatic int unsigned step_level(input int unsigned idx,
                                              input int unsigned l0,
                                              input int unsigned l1,
                                              input int unsigned l2,
                                              input int unsigned l3,
                                              input int unsigned depth);
      case (idx)
         0: return 0;
         1: return l0;
         2: return l1;
         3: return l2;
         4: return l3;
         default: return depth;
      endcase
   endfunction
endpackage

// File: rtl/flowctl_levels.sv
module flowctl_levels #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned LVL0  = 8,
   parameter int unsigned LVL1  = 16,
   parameter int unsigned LVL2  = 24,
   parameter int unsigned LVL3  = 28,
   parameter int unsigned CW    = 6
) (
   input  logic [1:0]    sel,
   output logic [CW-1:0] lvl_trig,
   output logic [CW-1:0] lvl_up,
   output logic [CW-1:0] lvl_dn
);
   localparam int unsigned NSTEP = 8;
   logic [CW-1:0] ladder [NSTEP];
   logic [2:0]    base;

   for (genvar i = 0; i < NSTEP; i++) begin : g_ladder
      assign ladder[i] = CW'(flowctl_pkg::step_level(i, LVL0, LVL1, LVL2, LVL3, DEPTH));
   end

   assign base     = {1'b0, sel};
   assign lvl_dn   = ladder[base];
   assign lvl_trig = ladder[base + 3'd1];
   assign lvl_up   = ladder[base + 3'd2];
endmodule

// File: rtl/flowctl_sync.sv
module flowctl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES == 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= 1'b0;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
   end
endmodule

// File: rtl/flowctl_rts.sv
module flowctl_rts #(
   parameter int unsigned CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [CW-1:0] fill,
   input  logic [CW-1:0] lvl_trig,
   input  logic [CW-1:0] lvl_up,
   input  logic [CW-1:0] lvl_dn,
   input  logic          sw_rts,
   output logic          rts_pin,
   output logic          irq
);
   logic hold_q, irq_q;
   logic raise, release_c;

   assign raise     = fill >= lvl_up;
   assign release_c = (fill < lvl_dn) || (fill == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= en && (fill >= lvl_trig);
         if (!en)            hold_q <= 1'b0;
         else if (raise)     hold_q <= 1'b1;
         else if (release_c) hold_q <= 1'b0;
      end
   end

   assign rts_pin = en ? hold_q : sw_rts;
   assign irq     = irq_q;
endmodule

// File: rtl/flowctl_txgate.sv
module flowctl_txgate (
   input  logic en,
   input  logic cts_s,
   input  logic tx_req,
   output logic tx_start
);
   assign tx_start = tx_req && !(en && cts_s);
endmodule

// File: rtl/uart_hw_flowctl.sv
module uart_hw_flowctl #(
   parameter  int unsigned DEPTH       = 32,
   parameter  int unsigned LVL0        = 8,
   parameter  int unsigned LVL1        = 16,
   parameter  int unsigned LVL2        = 24,
   parameter  int unsigned LVL3        = 28,
   parameter  int unsigned SYNC_STAGES = 2,
   parameter  int unsigned CTS_BIT     = 7,
   parameter  int unsigned RTS_BIT     = 6,
   localparam int unsigned CW          = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    feat_cfg,
   input  logic [1:0]    trig_sel,
   input  logic [CW-1:0] rx_fill,
   input  logic          sw_rts,
   input  logic          cts_pin,
   input  logic          tx_req,
   output logic          rts_pin,
   output logic          rx_trig_irq,
   output logic          tx_start
);
   if (!(LVL0 > 0 && LVL0 < LVL1 && LVL1 < LVL2 && LVL2 < LVL3 && LVL3 < DEPTH)) begin : g_bad_levels
      $error("trigger levels must rise strictly and stay below DEPTH");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (CTS_BIT > 7 || RTS_BIT > 7 || CTS_BIT == RTS_BIT) begin : g_bad_bits
      $error("enable bit positions must be distinct and within the byte");
   end

   logic          auto_cts, auto_rts, cts_s;
   logic [CW-1:0] lvl_trig, lvl_up, lvl_dn;

   assign auto_cts = feat_cfg[CTS_BIT];
   assign auto_rts = feat_cfg[RTS_BIT];

   flowctl_levels #(.DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2),
                    .LVL3(LVL3), .CW(CW)) u_levels (
      .sel(trig_sel), .lvl_trig(lvl_trig), .lvl_up(lvl_up), .lvl_dn(lvl_dn));

   flowctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cts_pin), .q(cts_s));

   flowctl_rts #(.CW(CW)) u_rts (
      .clk(clk), .rst_n(rst_n), .en(auto_rts), .fill(rx_fill),
      .lvl_trig(lvl_trig), .lvl_up(lvl_up), .lvl_dn(lvl_dn),
      .sw_rts(sw_rts), .rts_pin(rts_pin), .irq(rx_trig_irq));

   flowctl_txgate u_txgate (
      .en(auto_cts), .cts_s(cts_s), .tx_req(tx_req), .tx_start(tx_start));
endmodule

// File: rtl/uart_hw_flowctl_chk.sv
module uart_hw_flowctl_chk #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned LVL0  = 8,
   parameter int unsigned LVL1  = 16,
   parameter int unsigned LVL2  = 24,
   parameter int unsigned LVL3  = 28,
   parameter int unsigned CW    = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    feat_cfg,
   input logic [1:0]    trig_sel,
   input logic [CW-1:0] rx_fill,
   input logic          sw_rts,
   input logic          tx_req,
   input logic          rts_pin,
   input logic          rx_trig_irq,
   input logic          tx_start
);
   int unsigned f, t, u, d;
   assign f = int'(rx_fill);
   assign t = flowctl_pkg::step_level(trig_sel + 1, LVL0, LVL1, LVL2, LVL3, DEPTH);
   assign u = flowctl_pkg::step_level(trig_sel + 2, LVL0, LVL1, LVL2, LVL3, DEPTH);
   assign d = flowctl_pkg::step_level(int'(trig_sel), LVL0, LVL1, LVL2, LVL3, DEPTH);

   AST_IRQ_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (feat_cfg[6] && f >= t) |=> rx_trig_irq); // R3
   AST_IRQ_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      (f < t) |=> !rx_trig_irq); // R3
   AST_RTS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (feat_cfg[6] && f >= u) ##1 feat_cfg[6] |-> rts_pin); // R4
   AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (feat_cfg[6] && (f < d || f == 0)) ##1 feat_cfg[6] |-> !rts_pin); // R5
   AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (feat_cfg[6] && f < u && !(f < d || f == 0)) ##1 feat_cfg[6] |-> $stable(rts_pin)); // R5
   AST_RTS_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
      !feat_cfg[6] |-> (rts_pin == sw_rts)); // R6
   AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !feat_cfg[6] |=> !rx_trig_irq); // R6
   AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> tx_req); // R7
   AST_CTS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      !feat_cfg[7] |-> (tx_start == tx_req)); // R8
endmodule

bind uart_hw_flowctl uart_hw_flowctl_chk #(
   .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .feat_cfg(feat_cfg), .trig_sel(trig_sel),
   .rx_fill(rx_fill), .sw_rts(sw_rts), .tx_req(tx_req), .rts_pin(rts_pin),
   .rx_trig_irq(rx_trig_irq), .tx_start(tx_start));

// File: tb/sim_uart_hw_flowctl.sv
`timescale 1ns/1ps
module sim_uart_hw_flowctl;
   localparam int CW       = 6;
   localparam int CHAR_LEN = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    feat = 8'h00;
   logic [1:0]    sel = 2'd0;
   logic [CW-1:0] fill = '0;
   logic          sw_rts = 1'b1;
   logic          cts = 1'b0;
   logic          tx_req = 1'b0;
   logic          rts_pin, rx_trig_irq, tx_start;

   always #4 clk = ~clk;

   uart_hw_flowctl u0 (
      .clk(clk), .rst_n(rst_n), .feat_cfg(feat), .trig_sel(sel), .rx_fill(fill),
      .sw_rts(sw_rts), .cts_pin(cts), .tx_req(tx_req), .rts_pin(rts_pin),
      .rx_trig_irq(rx_trig_irq), .tx_start(tx_start));

   int trig_t [4] = '{8, 16, 24, 28};
   int up_t   [4] = '{16, 24, 28, 32};
   int dn_t   [4] = '{0, 8, 16, 24};

   // behavioural reference state
   logic m_c1, m_c2, m_hold, m_irq;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_c1 <= 0; m_c2 <= 0; m_hold <= 0; m_irq <= 0;
      end else begin
         m_c1  <= cts;
         m_c2  <= m_c1;
         m_irq <= feat[6] && (int'(fill) >= trig_t[sel]);
         if (!feat[6])                                m_hold <= 0;
         else if (int'(fill) >= up_t[sel])            m_hold <= 1;
         else if (int'(fill) < dn_t[sel] || fill == 0) m_hold <= 0;
      end
   end

   int checks = 0, errors = 0, cyc = 0;
   int pending = 0, busy = 0, starts = 0, last_start = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic tick();
      logic e_rts, e_irq, e_tx;
      @(negedge clk);
      cyc++;
      e_rts = feat[6] ? m_hold : sw_rts;
      e_irq = m_irq;
      e_tx  = tx_req && !(feat[7] && m_c2);
      chk(rts_pin == e_rts, !feat[6] ? "R6 rts follows sw" : (e_rts ? "R4 rts raise" : "R5 rts release"),
          rts_pin, e_rts);
      chk(rx_trig_irq == e_irq, "R3 trigger irq", rx_trig_irq, e_irq);
      chk(tx_start == e_tx, feat[7] ? "R7 cts gate" : "R8 cts bypass", tx_start, e_tx);
      if (busy > 0) busy--;
      if (tx_start) begin
         pending--; busy = CHAR_LEN; starts++; last_start = cyc;
      end
      tx_req = (pending > 0) && (busy == 0);
   endtask

   task automatic ramp(input int s);
      sel = 2'(s);
      for (int k = 0; k <= 32; k++) begin fill = CW'(k); tick(); end
      for (int k = 32; k >= 0; k--) begin fill = CW'(k); tick(); end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int c0;
      tick(); tick();
      chk(rx_trig_irq == 0, "R1 irq in reset", rx_trig_irq, 0);
      chk(rts_pin == 1, "R1 rts in reset", rts_pin, 1);
      rst_n = 1'b1;
      tick();
      chk(rx_trig_irq == 0 && rts_pin == sw_rts, "R1 after reset", rts_pin, sw_rts);

      // R2: low six bits only, nothing automatic
      feat = 8'h3F; fill = 6'd30; sw_rts = 0; cts = 1; pending = 1; tx_req = 1;
      tick(); tick(); tick();
      chk(rts_pin == 0 && rx_trig_irq == 0, "R2 low bits ignored (rts)", rts_pin, 0);
      chk(starts == 1, "R2 low bits ignored (tx)", starts, 1);
      cts = 0;
      // R6: software RTS follows
      feat = 8'h00; sw_rts = 1; tick();
      chk(rts_pin == 1, "R6 software rts", rts_pin, 1);
      sw_rts = 0; tick();
      chk(rts_pin == 0, "R6 software rts", rts_pin, 0);
      fill = 0; repeat (12) tick();

      // R3/R4/R5 across every trigger selection
      feat = 8'h40;
      for (int s = 0; s < 4; s++) ramp(s);

      // directed hysteresis points for selection 1
      sel = 2'd1;
      fill = 6'd16; tick(); tick();
      chk(rx_trig_irq == 1, "R3 irq at 16", rx_trig_irq, 1);
      chk(rts_pin == 0, "R4 not yet at 16", rts_pin, 0);
      fill = 6'd23; tick(); tick();
      chk(rts_pin == 0, "R4 not yet at 23", rts_pin, 0);
      fill = 6'd24; tick(); tick();
      chk(rts_pin == 1, "R4 raised at 24", rts_pin, 1);
      fill = 6'd8; tick(); tick();
      chk(rts_pin == 1 && rx_trig_irq == 0, "R5 held at 8", rts_pin, 1);
      fill = 6'd7; tick(); tick();
      chk(rts_pin == 0, "R5 released at 7", rts_pin, 0);
      // bottom step releases only when empty
      sel = 2'd0; fill = 6'd16; tick(); tick();
      fill = 6'd1; tick(); tick();
      chk(rts_pin == 1, "R5 held at 1", rts_pin, 1);
      fill = 6'd0; tick(); tick();
      chk(rts_pin == 0, "R5 released empty", rts_pin, 0);

      // R7: auto CTS, halt mid-character, resume point
      feat = 8'h80; cts = 0; pending = 3; tick();
      while (starts < 2) tick();
      repeat (3) tick();
      cts = 1;
      repeat (20) tick();
      chk(starts == 2, "R7 halted after current char", starts, 2);
      chk(busy == 0 && tx_req == 1, "R7 char completed, request waiting", busy, 0);
      cts = 0; c0 = cyc;
      while (starts < 3) tick();
      chk(last_start - c0 == 2, "R7 resume after two edges", last_start - c0, 2);

      // R8: CTS ignored when gating disabled
      feat = 8'h00; cts = 1; pending = 2; c0 = starts;
      repeat (25) tick();
      chk(starts == c0 + 2, "R8 sends despite cts", starts, c0 + 2);
      cts = 0; repeat (3) tick();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule